// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block holds the operating mode of a small microcontroller and drives the clock-domain controls that follow from it. It tracks five states: full-speed active, a slow subactive state that runs from the sub oscillator, a watch state, a standby state, and a transient state that waits for the main oscillator to settle. The CPU reports halt instructions through two strobes: a stop strobe and a standby strobe. Two software flags choose where those instructions lead. The first flag keeps low-speed operation on. The second flag requests a direct transfer to active. A wake request ends the watch and standby states. A ready signal from the main oscillator ends the settling wait.

The block turns its mode into three enables: one for the main oscillator, one for the sub oscillator and one for the A/D converter. It also keeps a speed-select bit, which picks the CPU cycle time while the part runs slowly. Software may change that bit only while the part is active. Any write attempted in another mode is dropped, and the attempt is recorded in a sticky error flag. Support for the subactive state is chosen at build time through a parameter. All outputs are registered and change on the clock edge that samples the stimulus.

Top module: `lpm_seq`

## Requirements
- R1: In subactive mode (mode code 1) the main oscillator enable is 0 and the sub oscillator enable is 1.
- R2: The A/D enable is 1 only in active mode (code 0). In every other mode it is 0.
- R3: A write strobe with data seen in active mode loads the speed-select output on the next edge. Reset clears the bit to 0, and a value of 1 selects the cycle time that is half as long.
- R4: A write strobe seen in any mode other than active leaves the speed-select bit unchanged and sets the error flag. The flag stays set until the clear strobe arrives, and a blocked write in the same cycle as the clear leaves the flag set.
- R5: A stop or standby strobe in subactive mode goes to the stabilizing state (code 4) when direct-transfer=1 and low-speed=0. With every other flag combination it goes to watch (code 2).
- R6: With the parameter SUBACT_EN=0, subactive mode is never entered. A stop with both flags set goes to watch, and a wake from watch with low-speed=1 goes to stabilizing.
- R7: The stabilizing state holds until oscillator-ready is 1 and then moves to active. Only the main oscillator is enabled while it waits.
- R8: Reset (synchronous, active high) puts the block in active mode with the main oscillator on, the sub oscillator off, A/D on, speed-select 0 and the error flag 0.
- R9: In active mode, a stop with both flags set enters subactive (when SUBACT_EN=1). Any other stop enters watch, and a standby strobe alone enters standby (code 3). Stop takes priority over standby, and a wake or a ready in active mode has no effect.
- R10: In standby a wake returns to active directly. In watch a wake goes to subactive when low-speed=1 (and SUBACT_EN=1), and otherwise to stabilizing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_i | input | 1 | Stop instruction strobe |
| sby_i | input | 1 | Standby instruction strobe |
| lson_i | input | 1 | Low-speed-on flag |
| dton_i | input | 1 | Direct-transfer-on flag |
| wake_i | input | 1 | Wake request (interrupt) |
| osc_rdy_i | input | 1 | Main oscillator stable |
| spd_wr_i | input | 1 | Speed-select write strobe |
| spd_wdata_i | input | 1 | Speed-select write data |
| err_clr_i | input | 1 | Clears the blocked-write error flag |
| mode_o | output | 3 | Current mode code (0 active, 1 subactive, 2 watch, 3 standby, 4 stabilizing) |
| main_osc_en_o | output | 1 | Main oscillator enable |
| sub_osc_en_o | output | 1 | Sub oscillator enable |
| adc_en_o | output | 1 | A/D converter enable |
| spd_sel_o | output | 1 | Speed-select bit |
| spd_err_o | output | 1 | Sticky blocked-write error flag |

## Verification
The hardest case to reach is a speed-select write that arrives while the part runs slowly. To get there, the bench first moves the block into subactive with a stop strobe, setting both flags in that same cycle. It then issues the write and checks that the speed-select output and the error flag behave as R4 requires. The subactive branch also depends on flag values that the CPU has to hold in the same cycle as the strobe. For that reason, the vector table walks every exit path out of subactive and watch in a single chain, starting from reset. A second instance built with the feature disabled receives the same stimulus, which confirms that the parameter removes the slow path.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [MODE_W-1:0] {
    MD_ACT   = 3'd0,
    MD_SUB   = 3'd1,
    MD_WATCH = 3'd2,
    MD_STBY  = 3'd3,
    MD_STAB  = 3'd4
  } lpm_mode_e;
endpackage

// File: rtl/lpm_next.sv
module lpm_next
  import lpm_pkg::*;
#(
  parameter bit SUBACT_EN = 1'b1
) (
  input  lpm_mode_e cur,
  input  logic      stop_i,
  input  logic      sby_i,
  input  logic      lson_i,
  input  logic      dton_i,
  input  logic      wake_i,
  input  logic      osc_rdy_i,
  output lpm_mode_e nxt
);
  logic halt;
  assign halt = stop_i | sby_i;

  always_comb begin
    nxt = cur;
    unique case (cur)
      MD_ACT: begin
        if (stop_i) begin
          if (SUBACT_EN && lson_i && dton_i) nxt = MD_SUB;
          else                               nxt = MD_WATCH;
        end else if (sby_i) begin
          nxt = MD_STBY;
        end
      end
      MD_SUB: begin
        if (halt) begin
          if (dton_i && !lson_i) nxt = MD_STAB;
          else                   nxt = MD_WATCH;
        end
      end
      MD_WATCH: begin
        if (wake_i) begin
          if (SUBACT_EN && lson_i) nxt = MD_SUB;
          else                     nxt = MD_STAB;
        end
      end
      MD_STBY: begin
        if (wake_i) nxt = MD_ACT;
      end
      MD_STAB: begin
        if (osc_rdy_i) nxt = MD_ACT;
      end
      default: nxt = MD_ACT;
    endcase
  end
endmodule

// File: rtl/lpm_speed.sv
module lpm_speed (
  input  logic clk,
  input  logic rst,
  input  logic wr_allowed,
  input  logic sel_wr,
  input  logic sel_wdata,
  input  logic err_clr,
  output logic sel_q,
  output logic err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (sel_wr && wr_allowed) sel_q <= sel_wdata;
      if (sel_wr && !wr_allowed) err_q <= 1'b1;
      else if (err_clr)          err_q <= 1'b0;
    end
  end

  p_blocked_write_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && !wr_allowed) |=> ($stable(sel_q) && err_q));

  p_allowed_write_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && wr_allowed) |=> (sel_q == $past(sel_wdata)));
endmodule

// File: rtl/lpm_seq.sv
module lpm_seq
  import lpm_pkg::*;
#(
  parameter bit SUBACT_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                stop_i,
  input  logic                sby_i,
  input  logic                lson_i,
  input  logic                dton_i,
  input  logic                wake_i,
  input  logic                osc_rdy_i,
  input  logic                spd_wr_i,
  input  logic                spd_wdata_i,
  input  logic                err_clr_i,
  output logic [MODE_W-1:0]   mode_o,
  output logic                main_osc_en_o,
  output logic                sub_osc_en_o,
  output logic                adc_en_o,
  output logic                spd_sel_o,
  output logic                spd_err_o
);
  lpm_mode_e state_q, state_d;

  lpm_next #(.SUBACT_EN(SUBACT_EN)) u_next (
    .cur       (state_q),
    .stop_i    (stop_i),
    .sby_i     (sby_i),
    .lson_i    (lson_i),
    .dton_i    (dton_i),
    .wake_i    (wake_i),
    .osc_rdy_i (osc_rdy_i),
    .nxt       (state_d)
  );

  // Mode and clock-domain enables registered together from the next mode.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= MD_ACT;
      main_osc_en_o <= 1'b1;
      sub_osc_en_o  <= 1'b0;
      adc_en_o      <= 1'b1;
    end else begin
      state_q       <= state_d;
      main_osc_en_o <= (state_d == MD_ACT) || (state_d == MD_STBY) || (state_d == MD_STAB);
      sub_osc_en_o  <= (state_d == MD_SUB) || (state_d == MD_WATCH);
      adc_en_o      <= (state_d == MD_ACT);
    end
  end

  assign mode_o = state_q;

  lpm_speed u_speed (
    .clk        (clk),
    .rst        (rst),
    .wr_allowed (state_q == MD_ACT),
    .sel_wr     (spd_wr_i),
    .sel_wdata  (spd_wdata_i),
    .err_clr    (err_clr_i),
    .sel_q      (spd_sel_o),
    .err_q      (spd_err_o)
  );

  p_sub_clocks_r1: assert property (@(posedge clk) disable iff (rst)
    (mode_o == MD_SUB) |-> (!main_osc_en_o && sub_osc_en_o));

  p_adc_active_only_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_o != MD_ACT) |-> !adc_en_o);

  p_sub_branch_r5: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == MD_SUB) && (stop_i || sby_i)) |=>
      (mode_o == (($past(dton_i) && !$past(lson_i)) ? MD_STAB : MD_WATCH)));

  p_no_sub_r6: assert property (@(posedge clk) disable iff (rst)
    (SUBACT_EN == 1'b0) |-> (mode_o != MD_SUB));

  p_stab_hold_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == MD_STAB) && !osc_rdy_i) |=> (mode_o == MD_STAB));

  p_stab_exit_r7: assert property (@(posedge clk) disable iff (rst)
    ((mode_o == MD_STAB) && osc_rdy_i) |=> (mode_o == MD_ACT));
endmodule

// File: tb/sim_lpm_seq.sv
module sim_lpm_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stop_i = 0, sby_i = 0, lson_i = 0, dton_i = 0, wake_i = 0, osc_rdy_i = 0;
  logic spd_wr_i = 0, spd_wdata_i = 0, err_clr_i = 0;
  logic [2:0] mode0, mode1;
  logic main0, sub0, adc0, spd0, err0;
  logic main1, sub1, adc1, spd1, err1;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lpm_seq #(.SUBACT_EN(1'b1)) u0 (
    .clk(clk), .rst(rst), .stop_i(stop_i), .sby_i(sby_i), .lson_i(lson_i),
    .dton_i(dton_i), .wake_i(wake_i), .osc_rdy_i(osc_rdy_i), .spd_wr_i(spd_wr_i),
    .spd_wdata_i(spd_wdata_i), .err_clr_i(err_clr_i), .mode_o(mode0),
    .main_osc_en_o(main0), .sub_osc_en_o(sub0), .adc_en_o(adc0),
    .spd_sel_o(spd0), .spd_err_o(err0));

  lpm_seq #(.SUBACT_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .stop_i(stop_i), .sby_i(sby_i), .lson_i(lson_i),
    .dton_i(dton_i), .wake_i(wake_i), .osc_rdy_i(osc_rdy_i), .spd_wr_i(spd_wr_i),
    .spd_wdata_i(spd_wdata_i), .err_clr_i(err_clr_i), .mode_o(mode1),
    .main_osc_en_o(main1), .sub_osc_en_o(sub1), .adc_en_o(adc1),
    .spd_sel_o(spd1), .spd_err_o(err1));

  // Vector: {stop, sby, lson, dton, wake, rdy, expected_mode[2:0]}
  localparam int NV = 18;
  localparam logic [8:0] VEC [0:NV-1] = '{
    {6'b000000, 3'd0},  // idle in active
    {6'b010000, 3'd3},  // R9 standby strobe
    {6'b000000, 3'd3},  // stay standby
    {6'b000010, 3'd0},  // R10 wake standby -> active
    {6'b100000, 3'd2},  // R9 stop, flags 0 -> watch
    {6'b000010, 3'd4},  // R10 wake lson 0 -> stabilizing
    {6'b000000, 3'd4},  // R7 wait without ready
    {6'b000001, 3'd0},  // R7 ready -> active
    {6'b101100, 3'd1},  // R9 stop both flags -> subactive
    {6'b010100, 3'd4},  // R5 sby dton=1 lson=0 -> stabilizing
    {6'b000001, 3'd0},  // R7 ready -> active
    {6'b111100, 3'd1},  // R9 stop priority over sby -> subactive
    {6'b101100, 3'd2},  // R5 both flags -> watch
    {6'b001010, 3'd1},  // R10 wake lson 1 -> subactive
    {6'b100000, 3'd2},  // R5 flags 0 -> watch
    {6'b000011, 3'd4},  // R10 wake lson 0 -> stabilizing (ready ignored in watch)
    {6'b000001, 3'd0},  // R7 ready -> active
    {6'b000011, 3'd0}   // R9 wake/ready ignored in active
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_mode0(input string req, input int exp);
    chk(req, "mode", int'(mode0), exp);
    chk("R1", "main_osc_en", int'(main0), int'(exp == 0 || exp == 3 || exp == 4));
    chk("R1", "sub_osc_en", int'(sub0), int'(exp == 1 || exp == 2));
    chk("R2", "adc_en", int'(adc0), int'(exp == 0));
  endtask

  task automatic drive(input logic [5:0] v);
    {stop_i, sby_i, lson_i, dton_i, wake_i, osc_rdy_i} = v;
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step();
    step();
    rst = 1'b0;
    // R8 reset state
    chk_mode0("R8", 0);
    chk("R8", "spd_sel", int'(spd0), 0);
    chk("R8", "spd_err", int'(err0), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][8:3]);
      step();
      chk_mode0($sformatf("R9/R10 vec%0d", i), int'(VEC[i][2:0]));
    end
    drive(6'b0);

    // R3 write in active
    spd_wr_i = 1; spd_wdata_i = 1;
    step();
    spd_wr_i = 0;
    chk("R3", "spd_sel", int'(spd0), 1);
    chk("R3", "spd_err", int'(err0), 0);

    // Enter subactive, then attempt a write
    drive(6'b101100);
    step();
    drive(6'b0);
    chk_mode0("R1", 1);
    spd_wr_i = 1; spd_wdata_i = 0;
    step();
    spd_wr_i = 0;
    chk("R4", "spd_sel held", int'(spd0), 1);
    chk("R4", "spd_err set", int'(err0), 1);
    step();
    chk("R4", "spd_err sticky", int'(err0), 1);
    // blocked write together with clear: flag stays set
    spd_wr_i = 1; err_clr_i = 1;
    step();
    spd_wr_i = 0;
    chk("R4", "spd_err set wins", int'(err0), 1);
    step();
    err_clr_i = 0;
    chk("R4", "spd_err cleared", int'(err0), 0);
    chk("R4", "spd_sel after clear", int'(spd0), 1);

    // R8 reset from subactive
    rst = 1;
    step();
    rst = 0;
    chk_mode0("R8", 0);
    chk("R8", "spd_sel", int'(spd0), 0);

    // R6 feature disabled instance
    drive(6'b101100);
    step();
    chk("R6", "u1 stop both flags", int'(mode1), 2);
    chk("R6", "u0 stop both flags", int'(mode0), 1);
    drive(6'b001010);
    step();
    chk("R6", "u1 wake lson=1", int'(mode1), 4);
    chk("R6", "u1 main_osc_en", int'(main1), 1);
    drive(6'b000001);
    step();
    drive(6'b0);
    chk("R6", "u1 ready", int'(mode1), 0);
    chk("R6", "u1 adc_en", int'(adc1), 1);

    finish_run();
  end
endmodule